// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt front end of a small CPU core. It takes one non-maskable request, three hardwired requests that can each be masked, and one general request. The general request's target comes from a restart opcode that the interrupting device places on an input. At every instruction-boundary strobe from the core it picks the single highest-priority eligible request. It then raises a one-cycle accept pulse and presents a 16-bit vector address to the core.

Software controls the unit through a few commands. An enable command and a disable command set and clear a global enable flag. A mask-write command carries three mask bits, a bit that says whether to apply them, and a bit that discards a latched edge on the highest hardwired source. A status word reports the mask, the global enable and the three hardwired pending bits, so a read-mask instruction can fetch it. Accepting any interrupt clears the global enable, so nesting occurs only when a service routine re-enables it. A separate output turns a software restart number n into its target address, n×8.

Top module: `prio_vec_intc`

## Requirements
- R1: While `rst` is high at a clock edge, the unit resets. After that edge `ack` is 0 and `vec_addr` is 0x0000. `mask_status` is 7'b000_0_111: nothing pending, enable clear, all three masks set. `sw_vec` is 0x0000.
- R2: At a strobe, priority runs from the non-maskable request, through the high source (src_req[2]) and the middle source (src_req[1]), to the low source (src_req[0]). The general request comes last. Exactly one request is accepted per strobe.
- R3: Each fixed source has its own vector: non-maskable 0x0024, high 0x003C, middle 0x0034, low 0x002C.
- R4: An accepted general request vectors to gen_opc[5:3]×8. `sw_vec` equals sw_num×8 one cycle after `sw_num` is applied.
- R5: `cmd_en` sets the global enable and `cmd_dis` clears it; when both are high, disable wins. While the enable is 0, no maskable source or general request is accepted, but the non-maskable request still is.
- R6: An acceptance clears the global enable at the same edge, and this clear wins over `cmd_en`. `ack` is high for exactly the one cycle after the accepting strobe edge, and `vec_addr` holds the accepted vector until the next acceptance.
- R7: A mask write updates the three masks (mask_wdata[2:0], bit i = 1 masks src_req[i]) only when mask_wdata[3] is 1. A masked source is never accepted. The general request is not affected by the mask.
- R8: The high source is edge-sensitive. A rising edge on src_req[2] sets a pending latch that holds until that source is accepted or a mask write with mask_wdata[4]=1 clears it. The low and middle sources are level-sensitive and are eligible only while their input is high at the strobe.
- R9: The non-maskable request is accepted only after a rising edge on `nmi_req`, and only if `nmi_req` is still high at the strobe. Its edge latch clears on acceptance, so it is not accepted a second time without a new edge.
- R10: mask_status[2:0] are the masks, mask_status[3] is the global enable, and mask_status[6:4] are the pending bits of the low, middle and high sources. These are the registered src_req[0], the registered src_req[1] and the high-source latch.
- R11: No request is accepted in a cycle where `insn_edge` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_edge | input | 1 | Instruction-boundary strobe; arbitration happens only here |
| nmi_req | input | 1 | Non-maskable request, rising edge plus level |
| src_req | input | 3 | Hardwired requests: [2] high (edge), [1] middle (level), [0] low (level) |
| gen_req | input | 1 | General request, gated only by the global enable |
| gen_opc | input | 8 | Restart opcode supplied with the general request |
| cmd_en | input | 1 | Enable command |
| cmd_dis | input | 1 | Disable command |
| mask_wr | input | 1 | Mask-write command strobe |
| mask_wdata | input | 5 | [2:0] masks, [3] apply masks, [4] clear high-source latch |
| sw_num | input | 3 | Software restart number |
| ack | output | 1 | One-cycle accept pulse |
| vec_addr | output | 16 | Vector address of the last accepted request |
| mask_status | output | 7 | {pending[2:0], global enable, mask[2:0]} |
| sw_vec | output | 16 | Software restart target, sw_num×8 |

## Verification
Each result is due at a known cycle after its stimulus:
- `ack`, `vec_addr` and the enable bit in `mask_status` change at the edge that samples `insn_edge`, so they are visible one cycle after the strobe is driven.
- The mask, the enable and the level pending bits follow their command or input one edge later.
- A rising edge on the high source or on the non-maskable input needs one edge to set its latch before a strobe can see it, so the bench raises these inputs one cycle ahead of the strobe.

The bench drives inputs just after a rising edge and samples just after the next one, so every check falls on the cycle where the result is first due.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int MASK_W  = 3;
  localparam int APPLY_B = 3;
  localparam int CLRHI_B = 4;
  localparam int RST_SH  = 3;
  localparam logic [15:0] VEC_NMI = 16'h0024;
  localparam logic [15:0] VEC_HI  = 16'h003C;
  localparam logic [15:0] VEC_MID = 16'h0034;
  localparam logic [15:0] VEC_LO  = 16'h002C;
endpackage

// File: rtl/intc_edge_cap.sv
module intc_edge_cap (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= din;
      pend_q <= (pend_q & ~clr) | (din & ~prev_q);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs #(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              take,
  input  logic              mask_wr,
  input  logic [MASK_W:0]   mask_wdata,
  output logic              ie,
  output logic [MASK_W-1:0] mask
);
  logic              ie_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (take || cmd_dis) ie_q <= 1'b0;
      else if (cmd_en)     ie_q <= 1'b1;
      if (mask_wr && mask_wdata[MASK_W]) mask_q <= mask_wdata[MASK_W-1:0];
    end
  end

  assign ie   = ie_q;
  assign mask = mask_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int OPC_W = 8
) (
  input  logic              insn_edge,
  input  logic              ie,
  input  logic [2:0]        mask,
  input  logic              nmi_ok,
  input  logic              hi_pend,
  input  logic [1:0]        lvl,
  input  logic              gen_req,
  input  logic [OPC_W-1:0]  gen_opc,
  output logic              take,
  output logic              sel_nmi,
  output logic              sel_hi,
  output logic [VEC_W-1:0]  vec
);
  logic [VEC_W-1:0] gen_vec;
  logic             opc_unused;

  assign gen_vec    = {{(VEC_W-6){1'b0}}, gen_opc[5:3], 3'b000};
  assign opc_unused = ^{gen_opc[OPC_W-1:6], gen_opc[2:0]};

  always_comb begin
    take    = insn_edge;
    sel_nmi = 1'b0;
    sel_hi  = 1'b0;
    vec     = '0;
    if (insn_edge && nmi_ok) begin
      sel_nmi = 1'b1;
      vec     = VEC_W'(VEC_NMI);
    end else if (insn_edge && ie && !mask[2] && hi_pend) begin
      sel_hi = 1'b1;
      vec    = VEC_W'(VEC_HI);
    end else if (insn_edge && ie && !mask[1] && lvl[1]) begin
      vec = VEC_W'(VEC_MID);
    end else if (insn_edge && ie && !mask[0] && lvl[0]) begin
      vec = VEC_W'(VEC_LO);
    end else if (insn_edge && ie && gen_req) begin
      vec = gen_vec;
    end else begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_edge,
  input  logic             nmi_req,
  input  logic [2:0]       src_req,
  input  logic             gen_req,
  input  logic [OPC_W-1:0] gen_opc,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             mask_wr,
  input  logic [4:0]       mask_wdata,
  input  logic [2:0]       sw_num,
  output logic             ack,
  output logic [VEC_W-1:0] vec_addr,
  output logic [6:0]       mask_status,
  output logic [VEC_W-1:0] sw_vec
);
  logic             nmi_pend, hi_pend;
  logic             take, sel_nmi, sel_hi;
  logic [VEC_W-1:0] vec_nxt;
  logic             ie;
  logic [2:0]       mask;
  logic [1:0]       lvl_q;
  logic             ack_q;
  logic [VEC_W-1:0] vec_q, sw_vec_q;

  intc_edge_cap u_nmi_cap (
    .clk(clk), .rst(rst), .din(nmi_req),
    .clr(take && sel_nmi), .pend(nmi_pend)
  );

  intc_edge_cap u_hi_cap (
    .clk(clk), .rst(rst), .din(src_req[2]),
    .clr((take && sel_hi) || (mask_wr && mask_wdata[CLRHI_B])),
    .pend(hi_pend)
  );

  intc_ctrl_regs #(.MASK_W(MASK_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .take(take), .mask_wr(mask_wr), .mask_wdata(mask_wdata[APPLY_B:0]),
    .ie(ie), .mask(mask)
  );

  intc_arbiter #(.VEC_W(VEC_W), .OPC_W(OPC_W)) u_arb (
    .insn_edge(insn_edge), .ie(ie), .mask(mask),
    .nmi_ok(nmi_pend && nmi_req), .hi_pend(hi_pend), .lvl(src_req[1:0]),
    .gen_req(gen_req), .gen_opc(gen_opc),
    .take(take), .sel_nmi(sel_nmi), .sel_hi(sel_hi), .vec(vec_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= 1'b0;
      vec_q    <= '0;
      lvl_q    <= '0;
      sw_vec_q <= '0;
    end else begin
      ack_q    <= take;
      if (take) vec_q <= vec_nxt;
      lvl_q    <= src_req[1:0];
      sw_vec_q <= VEC_W'({sw_num, {RST_SH{1'b0}}});
    end
  end

  assign ack         = ack_q;
  assign vec_addr    = vec_q;
  assign sw_vec      = sw_vec_q;
  assign mask_status = {hi_pend, lvl_q, ie, mask};
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_edge,
  input logic             nmi_req,
  input logic             mask_wr,
  input logic             ack,
  input logic [VEC_W-1:0] vec,
  input logic [6:0]       status
);
  // R6: the enable flag is already clear while the accept pulse is high
  a_r6_ie_clear: assert property (@(posedge clk) disable iff (rst)
    ack |-> !status[3]);

  // R11: no strobe, no accept pulse on the next cycle
  a_r11_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !insn_edge |=> !ack);

  // R5: any accepted vector other than the non-maskable one needed the enable
  a_r5_needs_ie: assert property (@(posedge clk) disable iff (rst)
    insn_edge ##1 (ack && vec != VEC_W'(16'h0024)) |-> $past(status[3]));

  // R9: a non-maskable acceptance needs the input high at the strobe
  a_r9_nmi_high: assert property (@(posedge clk) disable iff (rst)
    insn_edge ##1 (ack && vec == VEC_W'(16'h0024)) |-> $past(nmi_req));

  // R3: every accepted vector lies in the low restart page
  a_r3_vec_page: assert property (@(posedge clk) disable iff (rst)
    ack |-> (vec >> 6) == '0);

  // R7: masks move only on a mask write
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(status[2:0]));
endmodule

bind prio_vec_intc intc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .insn_edge(insn_edge), .nmi_req(nmi_req),
  .mask_wr(mask_wr), .ack(ack), .vec(vec_addr), .status(mask_status)
);

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_edge = 0, nmi_req = 0, gen_req = 0;
  logic [2:0]  src_req = 0;
  logic [7:0]  gen_opc = 8'hC7;
  logic        cmd_en = 0, cmd_dis = 0, mask_wr = 0;
  logic [4:0]  mask_wdata = 0;
  logic [2:0]  sw_num = 0;
  logic        ack;
  logic [15:0] vec_addr, sw_vec;
  logic [6:0]  mask_status;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_vec = 16'h0;

  always #2 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst(rst), .insn_edge(insn_edge), .nmi_req(nmi_req),
    .src_req(src_req), .gen_req(gen_req), .gen_opc(gen_opc),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .sw_num(sw_num), .ack(ack),
    .vec_addr(vec_addr), .mask_status(mask_status), .sw_vec(sw_vec)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic acc, acc_hi;
    logic [15:0] ev;

    repeat (3) tick();
    rst = 1'b0;
    check("R1 ack", ack, 0);
    check("R1 vec", vec_addr, 16'h0);
    check("R1 status", mask_status, 7'b000_0_111);
    check("R1 sw_vec", sw_vec, 16'h0);

    // sweep: enable x mask x {hi, mid, lo, gen}
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 8; m++)
        for (int r = 0; r < 16; r++) begin
          src_req = 0; gen_req = 0;
          mask_wr = 1; mask_wdata = {2'b11, 3'(m)}; cmd_dis = 1;
          tick();
          mask_wr = 0; cmd_dis = 0;
          src_req = {r[3], r[2], r[1]}; gen_req = r[0];
          gen_opc = {2'b11, 3'(r + m), 3'b111};
          cmd_en = e[0];
          tick();
          cmd_en = 0;
          check("R10 status", mask_status, {r[3], r[2], r[1], e[0], 3'(m)});
          acc = 1; acc_hi = 0; ev = last_vec;
          if (e == 0) acc = 0;
          else if (r[3] && !m[2]) begin ev = 16'h003C; acc_hi = 1; end
          else if (r[2] && !m[1]) ev = 16'h0034;
          else if (r[1] && !m[0]) ev = 16'h002C;
          else if (r[0]) ev = {10'b0, gen_opc[5:3], 3'b000};
          else acc = 0;
          insn_edge = 1;
          tick();
          insn_edge = 0;
          check("R2/R5/R7 ack", ack, acc);
          check("R2/R3/R4 vec", vec_addr, ev);
          check("R6 ie after", mask_status[3], e[0] && !acc);
          check("R8 hi pend", mask_status[6], r[3] && !acc_hi);
          last_vec = ev;
          src_req = 0; gen_req = 0;
          tick();
          check("R6 pulse", ack, 0);
        end

    // R9: non-maskable with enable clear, beats pending high source
    cmd_dis = 1; nmi_req = 1; src_req = 3'b100;
    tick();
    cmd_dis = 0;
    tick();
    insn_edge = 1; tick(); insn_edge = 0;
    check("R9 nmi ack", ack, 1);
    check("R3 nmi vec", vec_addr, 16'h0024);
    check("R8 hi stays", mask_status[6], 1);
    insn_edge = 1; tick(); insn_edge = 0;
    check("R9 no refire", ack, 0);

    // R7/R8: clear-only write keeps masks, drops high latch
    mask_wr = 1; mask_wdata = 5'b10_000;
    tick();
    mask_wr = 0;
    check("R7 no apply", mask_status[2:0], 3'b111);
    check("R8 cleared", mask_status[6], 0);

    // R9: glitch that falls before the strobe
    nmi_req = 0; tick();
    nmi_req = 1; tick();
    nmi_req = 0; tick();
    insn_edge = 1; tick(); insn_edge = 0;
    check("R9 glitch", ack, 0);

    // R5: disable wins over enable
    cmd_en = 1; cmd_dis = 1; tick();
    check("R5 dis wins", mask_status[3], 0);
    cmd_dis = 0; tick(); cmd_en = 0;
    check("R5 enable", mask_status[3], 1);

    // R11: no strobe, no accept
    src_req = 3'b000; mask_wr = 1; mask_wdata = 5'b01_000; tick(); mask_wr = 0;
    src_req = 3'b001; tick();
    check("R11 idle", ack, 0);
    tick();
    check("R11 idle2", ack, 0);
    insn_edge = 1; tick(); insn_edge = 0;
    check("R3 lo vec", vec_addr, 16'h002C);

    // R8: level source that drops before the strobe is lost
    cmd_en = 1; tick(); cmd_en = 0;
    src_req = 3'b000; tick();
    insn_edge = 1; tick(); insn_edge = 0;
    check("R8 level gone", ack, 0);

    // R8: high source pulse while disabled, served after enable
    cmd_dis = 1; src_req = 3'b100; tick(); cmd_dis = 0;
    src_req = 3'b000; tick();
    insn_edge = 1; tick(); insn_edge = 0;
    check("R5 blocked", ack, 0);
    check("R8 held", mask_status[6], 1);
    cmd_en = 1; tick(); cmd_en = 0;
    insn_edge = 1; tick(); insn_edge = 0;
    check("R8 served", ack, 1);
    check("R3 hi vec", vec_addr, 16'h003C);

    // R4: software restart targets
    for (int n = 0; n < 8; n++) begin
      sw_num = 3'(n);
      tick();
      check("R4 sw_vec", sw_vec, n * 8);
    end

    finish_run();
  end
endmodule